// File: doc/BRIEF.md
# SAR ADC Conversion Readout Controller

This block sits on the host side of a successive-approximation ADC that has a serial output. After a start pulse it raises the convert strobe and sets the level on the converter's serial input line. It then waits for the conversion to finish. The end of conversion is taken either from the converter's serial output, which acts as a busy flag, or from a fixed count of clock cycles. The block then lowers the chip select and shifts the result in with SPI mode 0 timing. Each finished word is shown for one cycle on a valid/data output, together with its position in the frame.

Three link styles are supported. In the three-wire style the serial input is held high and the convert strobe is only a short pulse. In the four-wire style the serial input is low and the convert strobe stays high. In the chained style several converters are connected in series, and one conversion yields one word per device. The converter's serial input may be driven by the host, tied high, tied low, or tied to the chip select. The wiring setting tells the block which of these applies, so the block knows what level the converter sees. The wiring setting also decides whether the block accepts a request for access to the converter's setup register.

Top module: `sar_readout_ctrl`

## Requirements
- R1: After reset: `cnv` is low, `cs_n` is high, `sclk` is low, `sdi_o` is high, `data_valid` is low, `timeout_err` is low, `active` is low and `overrun_cnt` is zero.
- R2: An accepted `start` raises `cnv` in the next cycle. With `link_mode`=0 (three-wire), `cnv` stays high for `CNV_PULSE` cycles and is then low, including during readout. With `link_mode` 1 or 3 (four-wire) or 2 (chained), `cnv` stays high through the wait and the readout.
- R3: `sdi_wiring` encodes the wiring: 0 = host-driven, 1 = tied high, 2 = tied low, 3 = tied to `cs_n`. During a conversion the host drives `sdi_o` high for three-wire and chained, and low for four-wire. With wiring 3, `cs_n` carries that same level until readout. `sdi_o` is high while idle.
- R4: With `busy_en`=1, readout starts only on a qualified edge of `sdo`. Three-wire needs a falling edge while the serial input level is high and `cnv` is low. Four-wire needs a falling edge while the serial input level is low and `cnv` is high. Chained needs a rising edge while both are high. `cs_n` falls one cycle after the edge is sampled.
- R5: With `busy_en`=0, `cs_n` falls `CONV_WAIT` cycles after the start is accepted, and `sdo` is not examined.
- R6: In readout, `cs_n` is low and `sclk` idles low. Bits are sampled on rising `sclk`, most significant bit first. Each `WIDTH` bits produce a one-cycle `data_valid` pulse with the word on `data_out`. `sclk` is never high while `cs_n` is high.
- R7: Chained mode reads `NDEV` words per conversion and emits them in arrival order, with `sample_idx` counting 0 to `NDEV`-1. The other modes emit one word with index 0.
- R8: Each `sclk` half period lasts `HALF` clock cycles, or 2×`HALF` in chained mode.
- R9: With `busy_en`=1, if no qualified edge arrives by the time `timeout_cyc` cycles have passed since `cnv` rose, `timeout_err` sets and the block returns to idle without emitting data. The next accepted start clears `timeout_err`.
- R10: A `start` seen while `active` is ignored and adds one to `overrun_cnt`, which saturates at all ones.
- R11: A `reg_req` pulse is answered one cycle later. It gets `reg_grant` only when `sdi_wiring`=0 and the block is idle. In every other case it gets `reg_reject`.
- R12: An edge that fails the level qualification is ignored. Examples are a wiring tied to the wrong level, or a three-wire edge that comes while `cnv` is still high. Such a run ends in a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request pulse |
| link_mode | input | 2 | 0 three-wire, 1/3 four-wire, 2 chained |
| sdi_wiring | input | 2 | Wiring of the converter's serial input (see R3) |
| busy_en | input | 1 | 1: use busy edge on `sdo`; 0: fixed wait |
| timeout_cyc | input | TO_W | Busy-edge timeout in cycles |
| reg_req | input | 1 | Setup-register access request |
| sdo | input | 1 | Converter serial output |
| cnv | output | 1 | Convert strobe |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock |
| sdi_o | output | 1 | Host drive for the converter's serial input |
| data_valid | output | 1 | One-cycle word strobe |
| data_out | output | WIDTH | Received word |
| sample_idx | output | max(1,clog2(NDEV)) | Word position in the frame |
| active | output | 1 | Conversion or readout in progress |
| timeout_err | output | 1 | Busy-edge timeout flag |
| overrun_cnt | output | OVR_W | Ignored-start counter |
| reg_grant | output | 1 | Register access accepted |
| reg_reject | output | 1 | Register access refused |

## Verification
The bench sweeps every link style against each wiring that suits it. It uses word patterns that include all zeros, all ones and computed mixes. It measures the delay from start to `cs_n` falling, both for the busy edge and for the fixed wait. A block that sampled on the wrong `sclk` edge, or that checked the wrong edge direction, would give shifted words or a spurious timeout. A block that did not halve the clock in chained mode would show the wrong `sclk` high time. Wrong-level wirings, an edge that arrives during the three-wire strobe, and a converter that never finishes must all end in a timeout with no data. A block that left out the level check would read garbage instead. Saturation of the overrun counter and refusal of register requests for each non-host wiring, and while busy, are also checked at the ports.

// File: rtl/sar_readout_ctrl.sv
module sar_readout_ctrl #(
  parameter int WIDTH     = 16,
  parameter int NDEV      = 2,
  parameter int HALF      = 2,
  parameter int CNV_PULSE = 3,
  parameter int CONV_WAIT = 24,
  parameter int TO_W      = 16,
  parameter int OVR_W     = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 start,
  input  logic [1:0]                           link_mode,
  input  logic [1:0]                           sdi_wiring,
  input  logic                                 busy_en,
  input  logic [TO_W-1:0]                      timeout_cyc,
  input  logic                                 reg_req,
  input  logic                                 sdo,
  output logic                                 cnv,
  output logic                                 cs_n,
  output logic                                 sclk,
  output logic                                 sdi_o,
  output logic                                 data_valid,
  output logic [WIDTH-1:0]                     data_out,
  output logic [$clog2(NDEV>1?NDEV:2)-1:0]     sample_idx,
  output logic                                 active,
  output logic                                 timeout_err,
  output logic [OVR_W-1:0]                     overrun_cnt,
  output logic                                 reg_grant,
  output logic                                 reg_reject
);
  localparam int DW = $clog2(NDEV > 1 ? NDEV : 2);
  localparam int BW = $clog2(WIDTH*NDEV + 1);
  localparam int WW = $clog2(WIDTH);
  localparam int HW = $clog2(2*HALF + 1);
  localparam logic [TO_W-1:0] PULSE_L = TO_W'(CNV_PULSE);
  localparam logic [TO_W-1:0] WAIT_L  = TO_W'(CONV_WAIT - 1);
  localparam logic [BW-1:0]   TOT_ALL = BW'(WIDTH*NDEV);
  localparam logic [BW-1:0]   TOT_ONE = BW'(WIDTH);
  localparam logic [WW-1:0]   WLAST   = WW'(WIDTH - 1);
  localparam logic [HW-1:0]   HSLOW   = HW'(2*HALF - 1);
  localparam logic [HW-1:0]   HFAST   = HW'(HALF - 1);
  localparam logic [1:0] M_THREE = 2'd0, M_CHAIN = 2'd2;
  localparam logic [1:0] W_HOST = 2'd0, W_HIGH = 2'd1, W_LOW = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_CONV, S_READ} st_t;

  st_t              st;
  logic [1:0]       mode_q, wir_q;
  logic             bsy_q, sclk_r, sdo_q, valid_r, err_r, grant_r, rej_r;
  logic [TO_W-1:0]  to_q, tmr;
  logic [HW-1:0]    div;
  logic [BW-1:0]    bits;
  logic [WW-1:0]    wcnt;
  logic [DW-1:0]    dev, idx_r;
  logic [WIDTH-1:0] shr, dout_r;
  logic [OVR_W-1:0] ovr_r;

  wire is_three = (mode_q == M_THREE);
  wire is_chain = (mode_q == M_CHAIN);
  wire need_sdi = is_three | is_chain;
  wire [HW-1:0] half_m1 = is_chain ? HSLOW : HFAST;
  wire [BW-1:0] total   = is_chain ? TOT_ALL : TOT_ONE;

  assign cnv   = (st == S_CONV && (!is_three || tmr < PULSE_L)) || (st == S_READ && !is_three);
  assign cs_n  = (st == S_READ) ? 1'b0 : (st == S_CONV && wir_q == 2'd3) ? need_sdi : 1'b1;
  assign sdi_o = (st == S_IDLE) ? 1'b1 : need_sdi;

  logic sdi_seen;
  always_comb begin
    case (wir_q)
      W_HOST:  sdi_seen = sdi_o;
      W_HIGH:  sdi_seen = 1'b1;
      W_LOW:   sdi_seen = 1'b0;
      default: sdi_seen = cs_n;
    endcase
  end

  wire fall_e = sdo_q & ~sdo;
  wire rise_e = ~sdo_q & sdo;
  wire eoc = is_three ? (fall_e & sdi_seen & ~cnv)
           : is_chain ? (rise_e & sdi_seen & cnv)
           :            (fall_e & ~sdi_seen & cnv);
  wire go_rd  = (st == S_CONV) && (bsy_q ? eoc : (tmr == WAIT_L));
  wire to_hit = (st == S_CONV) && bsy_q && !eoc && (tmr == to_q);
  wire reg_ok = (sdi_wiring == W_HOST) && (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; mode_q <= '0; wir_q <= '0; bsy_q <= 1'b0; to_q <= '0; tmr <= '0;
      div <= '0; bits <= '0; wcnt <= '0; dev <= '0; idx_r <= '0; shr <= '0; dout_r <= '0;
      sclk_r <= 1'b0; sdo_q <= 1'b0; valid_r <= 1'b0; err_r <= 1'b0; ovr_r <= '0;
      grant_r <= 1'b0; rej_r <= 1'b0;
    end else begin
      sdo_q   <= sdo;
      valid_r <= 1'b0;
      grant_r <= reg_req && reg_ok;
      rej_r   <= reg_req && !reg_ok;
      if (start && st != S_IDLE && ovr_r != '1) ovr_r <= ovr_r + OVR_W'(1);
      case (st)
        S_IDLE: if (start) begin
          st <= S_CONV; mode_q <= link_mode; wir_q <= sdi_wiring;
          bsy_q <= busy_en; to_q <= timeout_cyc; tmr <= '0; err_r <= 1'b0;
        end
        S_CONV: begin
          tmr <= tmr + TO_W'(1);
          if (go_rd) begin
            st <= S_READ; div <= '0; bits <= '0; wcnt <= '0; dev <= '0; sclk_r <= 1'b0;
          end else if (to_hit) begin
            err_r <= 1'b1; st <= S_IDLE;
          end
        end
        S_READ: begin
          if (div == half_m1) begin
            div    <= '0;
            sclk_r <= ~sclk_r;
            if (!sclk_r) begin
              shr  <= {shr[WIDTH-2:0], sdo};
              bits <= bits + BW'(1);
              if (wcnt == WLAST) begin
                wcnt <= '0; valid_r <= 1'b1; dout_r <= {shr[WIDTH-2:0], sdo};
                idx_r <= dev; dev <= dev + DW'(1);
              end else begin
                wcnt <= wcnt + WW'(1);
              end
            end else if (bits == total) begin
              st <= S_IDLE;
            end
          end else begin
            div <= div + HW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign sclk        = sclk_r;
  assign data_valid  = valid_r;
  assign data_out    = dout_r;
  assign sample_idx  = idx_r;
  assign active      = (st != S_IDLE);
  assign timeout_err = err_r;
  assign overrun_cnt = ovr_r;
  assign reg_grant   = grant_r;
  assign reg_reject  = rej_r;

  // R6
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk);
  // R6
  valid_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n) data_valid |-> !cs_n);
  // R10
  overrun_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && active && overrun_cnt != '1) |=> overrun_cnt == $past(overrun_cnt) + OVR_W'(1));
  // R11
  grant_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_grant |-> ($past(sdi_wiring) == W_HOST && !reg_reject));
  // R9
  timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(timeout_err) |-> !active);
  // R2
  three_cnv_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && mode_q == M_THREE) |-> !cnv);
endmodule

// File: tb/sar_readout_ctrl_tb.sv
module sar_readout_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int W = 16, ND = 2, HALF = 2, CNVP = 3, CWAIT = 24;

  logic clk = 0, rst_n = 0, start = 0, busy_en = 0, reg_req = 0, sdo = 1;
  logic [1:0] link_mode = 0, sdi_wiring = 0;
  logic [15:0] timeout_cyc = 16'd40;
  logic cnv, cs_n, sclk, sdi_o, data_valid, active, timeout_err, reg_grant, reg_reject;
  logic [W-1:0] data_out;
  logic [0:0] sample_idx;
  logic [7:0] overrun_cnt;

  sar_readout_ctrl #(.WIDTH(W), .NDEV(ND), .HALF(HALF), .CNV_PULSE(CNVP), .CONV_WAIT(CWAIT),
                     .TO_W(16), .OVR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .link_mode(link_mode), .sdi_wiring(sdi_wiring),
    .busy_en(busy_en), .timeout_cyc(timeout_cyc), .reg_req(reg_req), .sdo(sdo), .cnv(cnv),
    .cs_n(cs_n), .sclk(sclk), .sdi_o(sdi_o), .data_valid(data_valid), .data_out(data_out),
    .sample_idx(sample_idx), .active(active), .timeout_err(timeout_err),
    .overrun_cnt(overrun_cnt), .reg_grant(reg_grant), .reg_reject(reg_reject));

  always #(CLK_P/2) clk = ~clk;

  int nchk = 0, nerr = 0, cyc = 0;
  logic [W-1:0] words [ND];
  logic [W-1:0] got [ND];
  int gidx [ND];
  int nvalid = 0, hi_run = 0, last_hi = 0, m_delay = 10, conv_cnt = 0, bidx = 0;
  bit m_nodone = 0, done = 0;
  logic prev_cnv = 0, prev_sclk = 0;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic getbit(int i);
    int tot = (link_mode == 2) ? ND*W : W;
    if (i >= tot) return 1'b0;
    return words[i/W][W-1-(i%W)];
  endfunction

  // converter model, updated away from the active edge
  always @(negedge clk) begin
    if (cnv && !prev_cnv) begin
      sdo = (link_mode == 2) ? 1'b0 : 1'b1;
      conv_cnt = m_delay; done = 0; bidx = 0;
    end else if (!done && conv_cnt > 0) begin
      conv_cnt--;
      if (conv_cnt == 0 && !m_nodone) begin sdo = ~sdo; done = 1; end
    end else if (done && !cs_n) begin
      if (prev_sclk && !sclk) bidx++;
      sdo = getbit(bidx);
    end
    prev_cnv = cnv; prev_sclk = sclk;
    if (sclk) hi_run++;
    else begin if (hi_run > 0) last_hi = hi_run; hi_run = 0; end
    if (data_valid) begin
      if (nvalid < ND) begin got[nvalid] = data_out; gidx[nvalid] = int'(sample_idx); end
      nvalid++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      summary();
    end
  end

  task automatic set_words(input int p);
    for (int k = 0; k < ND; k++) begin
      if (p == 0) words[k] = '0;
      else if (p == 1) words[k] = '1;
      else words[k] = W'((p*32'h2F1B) ^ (k*32'h9D37) ^ (32'h1 << ((p+k) % W)));
    end
  endtask

  task automatic run(input int m, input int w, input int be, input int d, input bit nd, input bit ok);
    int n, lat, expn;
    logic c0, s0, cs0, cnvp, cnvr;
    bit need;
    @(negedge clk);
    link_mode = 2'(m); sdi_wiring = 2'(w); busy_en = 1'(be); m_delay = d; m_nodone = nd;
    nvalid = 0; last_hi = 0; start = 1;
    @(posedge clk); #1 start = 0;
    n = 0; lat = -1; c0 = 0; s0 = 0; cs0 = 0; cnvp = 0; cnvr = 0;
    while (n < 3000) begin
      @(negedge clk);
      if (n == 0) begin c0 = cnv; s0 = sdi_o; cs0 = cs_n; end
      if (n == CNVP) cnvp = cnv;
      if (!cs_n && lat < 0) begin lat = n; cnvr = cnv; end
      if (!active) break;
      n++;
    end
    need = (m == 0 || m == 2);
    chk("R2 cnv raised", c0, 1);
    chk("R2 cnv after pulse", cnvp, (m == 0) ? 0 : 1);
    if (w == 0) chk("R3 sdi_o level", s0, need);
    if (w == 3) chk("R3 cs_n level", cs0, need);
    if (ok) begin
      expn = (m == 2) ? ND : 1;
      if (w != 3) begin
        if (be != 0) chk("R4 eoc latency", lat, d + 1);
        else chk("R5 fixed wait", lat, CWAIT);
        chk("R2 cnv in readout", cnvr, (m == 0) ? 0 : 1);
      end
      chk("R6 word count", nvalid, expn);
      for (int k = 0; k < expn && k < nvalid; k++) begin
        chk("R6 word value", got[k], words[k]);
        chk("R7 word index", gidx[k], k);
      end
      chk("R8 sclk high time", last_hi, (m == 2) ? 2*HALF : HALF);
      chk("R9 no error", timeout_err, 0);
    end else begin
      chk("R12 timeout flag", timeout_err, 1);
      chk("R12 no data", nvalid, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cnv", cnv, 0); chk("R1 cs_n", cs_n, 1); chk("R1 sclk", sclk, 0);
    chk("R1 sdi_o", sdi_o, 1); chk("R1 valid", data_valid, 0); chk("R1 err", timeout_err, 0);
    chk("R1 active", active, 0); chk("R1 overrun", overrun_cnt, 0);
    rst_n = 1;
    @(negedge clk);

    // sweep link styles, matching wirings and word patterns
    for (int p = 0; p < 10; p++) begin
      set_words(p);
      run(0, 0, 1, 10, 0, 1); run(0, 1, 1, 10, 0, 1); run(0, 3, 1, 10, 0, 1);
      run(1, 0, 1, 10, 0, 1); run(1, 2, 1, 10, 0, 1); run(1, 3, 1, 10, 0, 1);
      run(2, 0, 1, 10, 0, 1); run(2, 1, 1, 10, 0, 1); run(3, 0, 1, 7, 0, 1);
      run(p % 3, 0, 0, 10, 0, 1);
    end

    // R12 mismatched wiring and early edge, R9 missing edge
    run(0, 2, 1, 10, 0, 0);
    run(1, 1, 1, 10, 0, 0);
    run(2, 2, 1, 10, 0, 0);
    run(0, 0, 1, 1, 0, 0);
    run(1, 0, 1, 10, 1, 0);
    set_words(4);
    run(1, 0, 1, 10, 0, 1);
    chk("R9 cleared by start", timeout_err, 0);

    // R11 register requests
    for (int w = 0; w < 4; w++) begin
      @(negedge clk); sdi_wiring = 2'(w); reg_req = 1;
      @(posedge clk); #1 reg_req = 0;
      @(negedge clk);
      chk("R11 grant", reg_grant, (w == 0) ? 1 : 0);
      chk("R11 reject", reg_reject, (w == 0) ? 0 : 1);
    end
    @(negedge clk); sdi_wiring = 0; link_mode = 0; busy_en = 0; m_delay = 10; start = 1;
    @(posedge clk); #1 start = 0;
    @(negedge clk); reg_req = 1;
    @(posedge clk); #1 reg_req = 0;
    @(negedge clk);
    chk("R11 grant while busy", reg_grant, 0);
    chk("R11 reject while busy", reg_reject, 1);
    while (active) @(negedge clk);

    // R10 overrun counting and saturation
    begin
      int base;
      base = int'(overrun_cnt);
      @(negedge clk); start = 1;
      @(posedge clk); #1 start = 0;
      for (int i = 0; i < 3; i++) begin
        @(negedge clk); start = 1; @(posedge clk); #1 start = 0;
      end
      while (active) @(negedge clk);
      chk("R10 overrun count", overrun_cnt, base + 3);
      @(negedge clk); start = 1;
      repeat (3000) @(negedge clk);
      start = 0;
      while (active) @(negedge clk);
      chk("R10 overrun saturate", overrun_cnt, 255);
      @(negedge clk); start = 1; @(posedge clk); #1 start = 0;
      @(negedge clk); start = 1; @(posedge clk); #1 start = 0;
      while (active) @(negedge clk);
      chk("R10 overrun stays", overrun_cnt, 255);
    end
    summary();
  end
endmodule